// File: doc/BRIEF.md
# Power-Fail Memory Enable Gate

This block is the digital half of a memory-protection supervisor. It sits between the host's chip-enable line and an external memory. An analog comparator reports whether the main supply has dropped below its trip level, and this block turns that report into three actions. First, it gates the memory chip-enable, which is active low. Second, it chooses which of two redundant backup batteries feeds the backup rail. Third, it raises an access-block flag that makes the timekeeper access path abort and refuse transfers.

A mode input tells the block whether the attached memory is RAM or ROM. During a power failure the two modes need opposite behaviour. RAM is write-protected by holding its enable inactive (high). ROM needs no protection, so its enable is driven low. Under a healthy supply the enable follows the host's enable with one register of delay. It is also held inactive while the access controller reports an open transfer window, so that the memory does not answer cycles meant for the timekeeper.

The comparator flag is asynchronous. It passes through a flop synchroniser before use. Entry into the failed state is immediate once the flag is synchronised. Exit waits for a parameterised run of consecutive healthy samples, which keeps a chattering comparator from toggling the protection.

Top module: `pf_mem_gate`

## Requirements
- R1: With `ram_rom_sel` = 0 (RAM) and the block in the failed state, `mem_ce_n` is 1.
- R2: With `ram_rom_sel` = 1 (ROM) and the block in the failed state, `mem_ce_n` is 0.
- R3: Under a healthy supply with `xfer_open` = 0, `mem_ce_n` equals the value `host_ce_n` had at the previous rising clock edge (one cycle of latency).
- R4: Under a healthy supply, `xfer_open` = 1 forces `mem_ce_n` to 1 on the following cycle, whatever `host_ce_n` is.
- R5: `tk_block` is 1 while the block is in the failed state. The failed state is left only after the synchronised fail flag has been 0 for RECOVER_CYCLES consecutive clock edges. Any renewed fail sample restarts that count. With a steady healthy supply, `tk_block` falls on the (RECOVER_CYCLES+3)-th rising edge after `supply_low` falls.
- R6: `supply_low` reaches `tk_block` through a two-flop synchroniser and two register stages. A rise of `supply_low` appears on `tk_block` at the 4th rising edge after the change, and not earlier.
- R7: In the failed state, with both batteries present, `use_bat2` = 1 and `use_bat1` = 0 exactly when `bat2_gt_bat1` = 1 and `bat1_gt_bat2` = 0. Otherwise `use_bat1` = 1 and `use_bat2` = 0.
- R8: In the failed state, with both batteries present and equal (both greater-than flags 0), battery 1 is selected (`use_bat1` = 1).
- R9: A battery whose present flag is 0 (input tied to ground) is never selected. If only one battery is present, that one is selected whatever the greater-than flags say. If neither is present, both select outputs are 0.
- R10: Under a healthy supply both `use_bat1` and `use_bat2` are 0 (main supply feeds the rail), and at most one select output is ever 1.
- R11: While `rst` is 1, and on the first edge after it, `mem_ce_n` = 1, `tk_block` = 1, `use_bat1` = 0 and `use_bat2` = 0. The block starts in the failed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low | input | 1 | Asynchronous comparator flag, 1 when main supply is below the trip level |
| ram_rom_sel | input | 1 | Memory type: 0 = RAM, 1 = ROM |
| host_ce_n | input | 1 | Host chip-enable for the memory, active low |
| xfer_open | input | 1 | Access controller reports an active timekeeper transfer window |
| bat1_present | input | 1 | Battery 1 is connected (not tied to ground) |
| bat2_present | input | 1 | Battery 2 is connected (not tied to ground) |
| bat1_gt_bat2 | input | 1 | Battery 1 voltage is above battery 2 |
| bat2_gt_bat1 | input | 1 | Battery 2 voltage is above battery 1 |
| mem_ce_n | output | 1 | Gated chip-enable to external memory, active low, registered |
| tk_block | output | 1 | Blocks and aborts timekeeper access, registered |
| use_bat1 | output | 1 | Backup rail fed from battery 1, registered |
| use_bat2 | output | 1 | Backup rail fed from battery 2, registered |

## Verification
On every cycle, the assertions enforce several rules. The enable level matches the memory mode while blocked. The enable follows the host line, or is forced high, while unblocked. The two battery selects are never both set, and neither is set under a healthy supply. A grounded battery is never picked. The filter enters the failed state one edge after a synchronised fail sample and leaves it only after a healthy one. The bench scenarios cover the properties that depend on counting edges or on input history: the exact four-edge entry latency, the recovery delay of RECOVER_CYCLES plus three edges, the restart of recovery after a single-cycle comparator glitch, and the reset values.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // Source feeding the backup rail.
  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_BAT1 = 2'b01,
    SRC_BAT2 = 2'b10
  } rail_src_t;

  // Default number of consecutive healthy samples needed to leave failure.
  localparam int DEF_RECOVER_CYCLES = 8;

  // Default synchroniser depth.
  localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  initial begin
    assert (STAGES >= 1) else $error("pfg_sync: STAGES must be at least 1");
  end

endmodule

// File: rtl/pfg_recover_filter.sv
module pfg_recover_filter #(
  parameter int RECOVER_CYCLES = 8,
  localparam int CNT_W = (RECOVER_CYCLES < 2) ? 1 : $clog2(RECOVER_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_s,
  output logic fail_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_CYCLES - 1);

  logic [CNT_W-1:0] ok_cnt;

  // Entry is immediate; exit needs RECOVER_CYCLES healthy samples in a row.
  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b1;
      ok_cnt <= '0;
    end else if (fail_s) begin
      fail_q <= 1'b1;
      ok_cnt <= '0;
    end else if (fail_q) begin
      if (ok_cnt == LAST) begin
        fail_q <= 1'b0;
        ok_cnt <= '0;
      end else begin
        ok_cnt <= ok_cnt + 1'b1;
      end
    end else begin
      ok_cnt <= '0;
    end
  end

  // R5: a synchronised fail sample always lands in the failed state.
  p_fast_entry_r5: assert property (@(posedge clk) disable iff (rst)
    fail_s |=> fail_q);

  // R5: leaving failure requires the last sample to have been healthy.
  p_exit_healthy_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_q) |-> !$past(fail_s));

  // R5: counter stays inside its window.
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    ok_cnt <= LAST);

  // R5: counter is idle outside the failed state.
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !fail_q |-> ok_cnt == '0);

  initial begin
    assert (RECOVER_CYCLES >= 1) else $error("pfg_recover_filter: RECOVER_CYCLES must be at least 1");
  end

endmodule

// File: rtl/pfg_batt_pick.sv
module pfg_batt_pick
  import pfg_pkg::*;
(
  input  logic      on_backup,
  input  logic      b1_present,
  input  logic      b2_present,
  input  logic      b1_gt_b2,
  input  logic      b2_gt_b1,
  output rail_src_t src
);

  always_comb begin
    src = SRC_MAIN;
    if (on_backup) begin
      unique case ({b1_present, b2_present})
        2'b11:   src = (b2_gt_b1 && !b1_gt_b2) ? SRC_BAT2 : SRC_BAT1;
        2'b10:   src = SRC_BAT1;
        2'b01:   src = SRC_BAT2;
        default: src = SRC_MAIN;
      endcase
    end
  end

  // R9: a missing battery is never chosen.
  always_comb begin
    if (!b1_present) assert (src != SRC_BAT1) else $error("p_no_gnd_b1_r9");
    if (!b2_present) assert (src != SRC_BAT2) else $error("p_no_gnd_b2_r9");
  end

endmodule

// File: rtl/pf_mem_gate.sv
module pf_mem_gate
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES    = DEF_SYNC_STAGES,
  parameter int RECOVER_CYCLES = DEF_RECOVER_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic ram_rom_sel,
  input  logic host_ce_n,
  input  logic xfer_open,
  input  logic bat1_present,
  input  logic bat2_present,
  input  logic bat1_gt_bat2,
  input  logic bat2_gt_bat1,
  output logic mem_ce_n,
  output logic tk_block,
  output logic use_bat1,
  output logic use_bat2
);

  logic      fail_s;
  logic      fail_q;
  rail_src_t src;
  logic      ce_n_next;

  pfg_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (supply_low),
    .q   (fail_s)
  );

  pfg_recover_filter #(
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) u_filter (
    .clk    (clk),
    .rst    (rst),
    .fail_s (fail_s),
    .fail_q (fail_q)
  );

  pfg_batt_pick u_pick (
    .on_backup  (fail_q),
    .b1_present (bat1_present),
    .b2_present (bat2_present),
    .b1_gt_b2   (bat1_gt_bat2),
    .b2_gt_b1   (bat2_gt_bat1),
    .src        (src)
  );

  // Failure dominates; then the transfer window; then pass-through.
  always_comb begin
    if (fail_q)         ce_n_next = !ram_rom_sel;
    else if (xfer_open) ce_n_next = 1'b1;
    else                ce_n_next = host_ce_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n <= 1'b1;
      tk_block <= 1'b1;
      use_bat1 <= 1'b0;
      use_bat2 <= 1'b0;
    end else begin
      mem_ce_n <= ce_n_next;
      tk_block <= fail_q;
      use_bat1 <= (src == SRC_BAT1);
      use_bat2 <= (src == SRC_BAT2);
    end
  end

  // R1: RAM held inactive while blocked.
  p_ram_protect_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tk_block && !$past(ram_rom_sel)) |-> mem_ce_n);

  // R2: ROM driven low while blocked.
  p_rom_low_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tk_block && $past(ram_rom_sel)) |-> !mem_ce_n);

  // R3: pass-through with one cycle of latency.
  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !tk_block && !$past(xfer_open)) |-> mem_ce_n == $past(host_ce_n));

  // R4: transfer window keeps memory deselected.
  p_xfer_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !tk_block && $past(xfer_open)) |-> mem_ce_n);

  // R10: never both batteries.
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({use_bat1, use_bat2}));

  // R10: healthy supply uses the main rail.
  p_main_rail_r10: assert property (@(posedge clk) disable iff (rst)
    !tk_block |-> !use_bat1 && !use_bat2);

  // R9: a grounded battery input is never selected.
  p_gnd_b1_r9: assert property (@(posedge clk) disable iff (rst)
    use_bat1 |-> $past(bat1_present));
  p_gnd_b2_r9: assert property (@(posedge clk) disable iff (rst)
    use_bat2 |-> $past(bat2_present));

  // R8: equal batteries prefer battery 1.
  p_tie_b1_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tk_block && $past(bat1_present && bat2_present
      && !bat1_gt_bat2 && !bat2_gt_bat1)) |-> use_bat1);

endmodule

// File: tb/pf_mem_gate_test.sv
module pf_mem_gate_test;

  localparam int RC = 8;
  localparam int SETTLE = RC + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic ram_rom_sel = 1'b0;
  logic host_ce_n = 1'b1;
  logic xfer_open = 1'b0;
  logic bat1_present = 1'b1;
  logic bat2_present = 1'b1;
  logic bat1_gt_bat2 = 1'b0;
  logic bat2_gt_bat1 = 1'b0;
  logic mem_ce_n, tk_block, use_bat1, use_bat2;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pf_mem_gate #(.SYNC_STAGES(2), .RECOVER_CYCLES(RC)) uut (
    .clk(clk), .rst(rst), .supply_low(supply_low), .ram_rom_sel(ram_rom_sel),
    .host_ce_n(host_ce_n), .xfer_open(xfer_open),
    .bat1_present(bat1_present), .bat2_present(bat2_present),
    .bat1_gt_bat2(bat1_gt_bat2), .bat2_gt_bat1(bat2_gt_bat1),
    .mem_ce_n(mem_ce_n), .tk_block(tk_block), .use_bat1(use_bat1), .use_bat2(use_bat2)
  );

  // {supply_low, rom, host_ce_n, xfer, b1p, b2p, b1gt, b2gt, exp_ce, exp_blk, exp_s1, exp_s2}
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_1100_0000, // R3 follow low
    12'b0010_1100_1000, // R3 follow high
    12'b0001_1100_1000, // R4 window forces high
    12'b0100_1110_0000, // R10 ROM, healthy, main rail
    12'b1000_1100_1110, // R1 RAM protect, R8 tie to bat1
    12'b1110_1101_0101, // R2 ROM low, R7 bat2 higher
    12'b1001_1110_1110, // R7 bat1 higher
    12'b1101_0110_0101, // R9 bat1 grounded
    12'b1000_1001_1110, // R9 bat2 grounded
    12'b1000_0000_1100, // R9 none present
    12'b0110_0000_1000  // R10 recovery, main rail
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_vec(input logic [7:0] v);
    @(negedge clk);
    {supply_low, ram_rom_sel, host_ce_n, xfer_open,
     bat1_present, bat2_present, bat1_gt_bat2, bat2_gt_bat1} = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin : watchdog
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R11 reset state
    edges(3);
    check("R11 mem_ce_n", mem_ce_n, 1'b1);
    check("R11 tk_block", tk_block, 1'b1);
    check("R11 use_bat1", use_bat1, 1'b0);
    check("R11 use_bat2", use_bat2, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    edges(1);
    check("R11 first edge tk_block", tk_block, 1'b1);
    check("R11 first edge mem_ce_n", mem_ce_n, 1'b1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive_vec(VEC[i][11:4]);
      edges(SETTLE);
      check($sformatf("vec%0d mem_ce_n R1/R2/R3/R4", i), mem_ce_n, VEC[i][3]);
      check($sformatf("vec%0d tk_block R5", i), tk_block, VEC[i][2]);
      check($sformatf("vec%0d use_bat1 R7/R8/R9/R10", i), use_bat1, VEC[i][1]);
      check($sformatf("vec%0d use_bat2 R7/R9/R10", i), use_bat2, VEC[i][0]);
    end

    // R3 exact latency: healthy, RAM, host_ce_n was 1
    drive_vec(8'b0010_1100);
    edges(SETTLE);
    @(negedge clk);
    host_ce_n = 1'b0;
    #1 check("R3 before edge", mem_ce_n, 1'b1);
    edges(1);
    check("R3 one-cycle latency", mem_ce_n, 1'b0);

    // R4 window overrides low host enable
    @(negedge clk);
    xfer_open = 1'b1;
    edges(1);
    check("R4 window forces high", mem_ce_n, 1'b1);
    @(negedge clk);
    xfer_open = 1'b0;
    edges(1);
    check("R4 window release", mem_ce_n, 1'b0);

    // R6 entry latency
    @(negedge clk);
    supply_low = 1'b1;
    edges(3);
    check("R6 not before 4th edge", tk_block, 1'b0);
    edges(1);
    check("R6 at 4th edge", tk_block, 1'b1);
    check("R1 RAM enable high on entry", mem_ce_n, 1'b1);

    // R5 recovery delay
    edges(SETTLE);
    @(negedge clk);
    supply_low = 1'b0;
    edges(RC + 2);
    check("R5 still blocked at RC+2", tk_block, 1'b1);
    edges(1);
    check("R5 released at RC+3", tk_block, 1'b0);

    // R5 glitch restarts recovery
    @(negedge clk);
    supply_low = 1'b1;
    edges(SETTLE);
    @(negedge clk);
    supply_low = 1'b0;
    edges(RC - 2);
    @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    edges(RC + 1);
    check("R5 glitch restarts count", tk_block, 1'b1);
    edges(SETTLE);
    check("R5 released after glitch", tk_block, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule